// File: doc/BRIEF.md
# Receive Statistics Counter Bank with Threshold Interrupts

This block keeps five receive-side event counters, one each for frames that failed the CRC check, frames with an alignment error, good unicast frames, microseconds spent in low-power idle, and entries into low-power idle. The receive path drives one increment strobe per counter. Each counter has its own pending bit in a shared 32-bit status word. That bit is raised twice per trip through the counter's range. It is raised once when the count first reaches the midpoint of the range. It is raised again when an increment arrives while the count is at all ones.

A control input picks what happens at the top of the range. When it is low, the counter wraps to zero. When it is high, the counter saturates at all ones. Software reads the counters and the status word over a plain read port with byte-lane enables. A pending bit is cleared by reading its counter with the lowest byte lane enabled. Reading the status word, or reading the counter through the upper lanes only, leaves the bit set.

A per-counter mask keeps a pending bit out of the combined interrupt output without stopping the bit from being recorded. A bulk-clear input zeroes every counter at once and leaves the pending bits as they are. The counter width is a parameter (32 by default). The midpoint and all-ones thresholds follow from that width.

Top module: `rx_stat_bank`

## Requirements
- R1: While reset is held, and in the first cycle after it, every counter reads zero, the status word reads zero, `irq_o` is 0 and `rd_valid_o` is 0.
- R2: A high `inc_i[k]` adds one to counter k at the clock edge. The counter index is 0 for CRC errors, 1 for alignment errors, 2 for good unicast, 3 for LPI microseconds and 4 for LPI entries. A read at word address k (0 to 4) returns counter k, zero-extended to 32 bits, one cycle after `rd_en_i`, with `rd_valid_o` high in that cycle. Byte lane j is bits [8j+7:8j] of the word. A lane whose `rd_be_i[j]` is 0 reads zero. Addresses 6 and 7 read zero.
- R3: An increment that takes counter k from midpoint-minus-one to the midpoint sets its pending bit. The midpoint is a 1 in the top bit of the counter with zeros below it. No other increment below all ones sets the bit.
- R4: With `stop_roll_i` low, an increment at all ones wraps the counter to zero and sets its pending bit on that same edge.
- R5: With `stop_roll_i` high, an increment at all ones leaves the counter at all ones and sets its pending bit.
- R6: Word address 5 returns the status word. Bit 5 holds counter 0, bit 6 counter 1, bit 17 counter 2, bit 26 counter 3 and bit 27 counter 4. All other bits read 0. Reading this word clears nothing.
- R7: A read at address k with `rd_be_i[0]` = 1 clears pending bit k at that edge. A read of counter k with `rd_be_i[0]` = 0 leaves the bit unchanged.
- R8: If a clearing read of counter k and a set event for counter k fall in the same cycle, the pending bit ends up set.
- R9: `irq_o` is high exactly when some pending bit k is set and `irq_mask_i[k]` is 0. A masked counter still records its pending bit.
- R10: A high `cnt_clr_i` zeroes every counter at that edge. This overrides an increment in the same cycle, and that increment raises no event. Pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 5 | Per-counter increment strobes |
| stop_roll_i | input | 1 | 1: saturate at all ones; 0: wrap to zero |
| cnt_clr_i | input | 1 | Zero all counters |
| irq_mask_i | input | 5 | 1 keeps counter k out of `irq_o` |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 3 | Word address: 0-4 counters, 5 status |
| rd_be_i | input | 4 | Byte-lane enables for the read |
| rd_data_o | output | 32 | Read data, valid one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | OR of the unmasked pending bits |

## Verification
The bench builds a narrow counter so that both thresholds can be reached. It goes after the midpoint crossing, the wrap at all ones and saturation. A design that compared with the wrong threshold would raise the bit one step early or late, or again on every later increment. A wrap-off-by-one would show up as a count of 1, or as a missing pending bit. The bench reads through the upper lanes only and checks that the bit is still pending. It also lines up a clearing read with a new event in the same cycle. Getting the priority backwards would lose that interrupt. The bench also fires a bulk clear together with an increment, and flips the mask while bits are pending. Each of these exposes a design that drops the pending bits on clear or that gates recording with the mask.

// File: rtl/rxs_pkg.sv
// Package: shared constants for the receive statistics bank.
// Assumes a 32-bit read bus and five counters whose status bit positions are fixed.
package rxs_pkg;
    localparam int NUM_CNT  = 5;
    localparam int BUS_W    = 32;
    localparam int BE_W     = BUS_W / 8;
    localparam int STS_ADDR = NUM_CNT;
    localparam int STS_POS [NUM_CNT] = '{5, 6, 17, 26, 27};

    // Counter index per receive event
    typedef enum int {
        IDX_CRC   = 0,
        IDX_ALIGN = 1,
        IDX_UCAST = 2,
        IDX_LPI_US = 3,
        IDX_LPI_TR = 4
    } cnt_idx_e;
endpackage

// File: rtl/rxs_counter.sv
// Module: one statistics counter with midpoint and top-of-range events.
// Assumes increments of one per cycle, so the midpoint is crossed only from midpoint-1.
// The event output is combinational and valid in the cycle of the increment.
module rxs_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             stop_roll_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o
);
    localparam logic [CNT_W-1:0] TOP_VAL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MID_PRE  = {1'b0, {(CNT_W-1){1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic             at_top;
    logic             at_mid_pre;

    // Threshold compare and event strobe for the current increment
    always_comb begin
        at_top     = (cnt_q == TOP_VAL);
        at_mid_pre = (cnt_q == MID_PRE);
        evt_o      = inc_i && !clr_i && (at_top || at_mid_pre);
    end

    // Count register: clear, saturate or wrap, else add one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            if (at_top) begin
                cnt_q <= stop_roll_i ? TOP_VAL : '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rxs_irq_status.sv
// Module: pending bits for all counters and the combined interrupt.
// Assumes set and clear arrive as single-cycle strobes; set has priority over clear.
module rxs_irq_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] sts_o,
    output logic         irq_o
);
    logic [N-1:0] sts_q;

    // Pending bits: per-bit set-over-clear update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (set_i[k]) begin
                    sts_q[k] <= 1'b1;
                end else if (clr_i[k]) begin
                    sts_q[k] <= 1'b0;
                end
            end
        end
    end

    // Interrupt line: any pending bit not masked
    always_comb begin
        irq_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            irq_o = irq_o | (sts_q[k] & ~mask_i[k]);
        end
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/rxs_read_port.sv
// Module: address decode, byte-lane masking and registered read data.
// Assumes CNT_W <= 32; counters are zero-extended to the bus width.
// Also produces the per-counter clear strobes for reads that include lane 0.
module rxs_read_port
    import rxs_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N      = NUM_CNT,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [BE_W-1:0]          rd_be_i,
    input  logic [N-1:0][CNT_W-1:0]  cnt_i,
    input  logic [N-1:0]             sts_i,
    output logic [BUS_W-1:0]         rd_data_o,
    output logic                     rd_valid_o,
    output logic [N-1:0]             rd_clr_o
);
    logic [N-1:0][BUS_W-1:0] cnt_ext;
    logic [BUS_W-1:0]        sts_word;
    logic [BUS_W-1:0]        sel_word;
    logic [BUS_W-1:0]        lane_mask;
    logic [BUS_W-1:0]        data_q;
    logic                    valid_q;

    // Zero-extend each counter to the bus width
    for (genvar k = 0; k < N; k++) begin : g_ext
        if (CNT_W < BUS_W) begin : g_pad
            assign cnt_ext[k] = {{(BUS_W-CNT_W){1'b0}}, cnt_i[k]};
        end else begin : g_full
            assign cnt_ext[k] = cnt_i[k][BUS_W-1:0];
        end
    end

    // Expand byte enables into a bit mask
    for (genvar j = 0; j < BE_W; j++) begin : g_lane
        assign lane_mask[8*j +: 8] = {8{rd_be_i[j]}};
    end

    // Place pending bits at their status word positions
    always_comb begin
        sts_word = '0;
        for (int k = 0; k < N; k++) begin
            sts_word[STS_POS[k]] = sts_i[k];
        end
    end

    // Select the addressed word
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_addr_i == ADDR_W'(k)) begin
                sel_word = cnt_ext[k];
            end
        end
        if (rd_addr_i == ADDR_W'(STS_ADDR)) begin
            sel_word = sts_word;
        end
    end

    // Clearing strobe: read of counter k with the lowest lane enabled
    always_comb begin
        for (int k = 0; k < N; k++) begin
            rd_clr_o[k] = rd_en_i && rd_be_i[0] && (rd_addr_i == ADDR_W'(k));
        end
    end

    // Read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en_i;
            data_q  <= rd_en_i ? (sel_word & lane_mask) : '0;
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;
endmodule

// File: rtl/rx_stat_bank.sv
// Module: top of the receive statistics bank.
// Ties five counters, the pending-bit register and the read port together.
// Assumes the receive path drives at most one strobe per counter per cycle.
module rx_stat_bank
    import rxs_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CNT-1:0]  inc_i,
    input  logic                stop_roll_i,
    input  logic                cnt_clr_i,
    input  logic [NUM_CNT-1:0]  irq_mask_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [BE_W-1:0]     rd_be_i,
    output logic [BUS_W-1:0]    rd_data_o,
    output logic                rd_valid_o,
    output logic                irq_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0]            evt;
    logic [NUM_CNT-1:0]            rd_clr;
    logic [NUM_CNT-1:0]            sts_q;

    // One counter per receive event
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        rxs_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .inc_i       (inc_i[k]),
            .stop_roll_i (stop_roll_i),
            .clr_i       (cnt_clr_i),
            .cnt_o       (cnt_val[k]),
            .evt_o       (evt[k])
        );
    end

    rxs_irq_status #(.N(NUM_CNT)) u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt),
        .clr_i  (rd_clr),
        .mask_i (irq_mask_i),
        .sts_o  (sts_q),
        .irq_o  (irq_o)
    );

    rxs_read_port #(.CNT_W(CNT_W), .N(NUM_CNT), .ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_be_i    (rd_be_i),
        .cnt_i      (cnt_val),
        .sts_i      (sts_q),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .rd_clr_o   (rd_clr)
    );
endmodule

// File: rtl/rxs_chk.sv
// Module: assertion checker bound to rx_stat_bank.
// Observes ports plus the event, clear and pending vectors driven by separate submodules.
module rxs_chk #(
    parameter int N     = 5,
    parameter int CNT_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N-1:0]            inc_i,
    input logic                    stop_roll_i,
    input logic                    cnt_clr_i,
    input logic [N-1:0]            irq_mask_i,
    input logic                    rd_en_i,
    input logic                    rd_valid_o,
    input logic                    irq_o,
    input logic [N-1:0][CNT_W-1:0] cnt_val,
    input logic [N-1:0]            evt,
    input logic [N-1:0]            rd_clr,
    input logic [N-1:0]            sts_q
);
    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    // R9
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask_i) |-> !irq_o);

    for (genvar k = 0; k < N; k++) begin : g_k
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> sts_q[k]);

        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[k] && !evt[k]) |=> !sts_q[k]);

        // R5
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_roll_i && inc_i[k] && !cnt_clr_i && (&cnt_val[k])) |=> (&cnt_val[k]));

        // R4
        wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_roll_i && inc_i[k] && !cnt_clr_i && (&cnt_val[k])) |=> (cnt_val[k] == '0));

        // R10
        bulk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_clr_i |=> (cnt_val[k] == '0));
    end
endmodule

bind rx_stat_bank rxs_chk #(.N(rxs_pkg::NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc_i),
    .stop_roll_i (stop_roll_i),
    .cnt_clr_i   (cnt_clr_i),
    .irq_mask_i  (irq_mask_i),
    .rd_en_i     (rd_en_i),
    .rd_valid_o  (rd_valid_o),
    .irq_o       (irq_o),
    .cnt_val     (cnt_val),
    .evt         (evt),
    .rd_clr      (rd_clr),
    .sts_q       (sts_q)
);

// File: tb/sim_rx_stat_bank.sv
// Bench: behavioural reference model compared on every clock.
module sim_rx_stat_bank;
    localparam int CW   = 8;
    localparam int MAXV = (1 << CW) - 1;
    localparam int MIDV = 1 << (CW - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  inc = '0;
    logic        stop = 1'b0;
    logic        cclr = 1'b0;
    logic [4:0]  mask = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [3:0]  rd_be = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int unsigned mcnt [5];
    bit          msts [5];
    int          spos [5] = '{5, 6, 17, 26, 27};

    always #2 clk = ~clk;

    rx_stat_bank #(.CNT_W(CW), .ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .stop_roll_i(stop),
        .cnt_clr_i(cclr), .irq_mask_i(mask), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_be_i(rd_be), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int a, input logic [3:0] be);
        logic [31:0] w = '0;
        logic [31:0] m = '0;
        if (a < 5) w = mcnt[a];
        else if (a == 5) for (int k = 0; k < 5; k++) w[spos[k]] = msts[k];
        for (int j = 0; j < 4; j++) if (be[j]) m[8*j +: 8] = 8'hFF;
        return w & m;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        for (int k = 0; k < 5; k++) r |= msts[k] & ~mask[k];
        return r;
    endfunction

    // One clock: model update at the edge, compare at the following falling edge
    task automatic step(input string tag);
        logic [31:0] ew;
        bit          was_rd;
        bit          ev;
        was_rd = rd_en;
        ew = exp_word(int'(rd_addr), rd_be);
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            ev = 0;
            if (cclr) mcnt[k] = 0;
            else if (inc[k]) begin
                if (mcnt[k] == MIDV - 1) ev = 1;
                if (mcnt[k] == MAXV) begin
                    ev = 1;
                    if (!stop) mcnt[k] = 0;
                end else mcnt[k]++;
            end
            if (ev) msts[k] = 1;
            else if (rd_en && rd_be[0] && int'(rd_addr) == k) msts[k] = 0;
        end
        @(negedge clk);
        chk({tag, " valid"}, {31'b0, rd_valid}, {31'b0, was_rd});
        if (was_rd) chk({tag, " data"}, rd_data, ew);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
        inc = '0; cclr = 0; rd_en = 0; rd_be = '0; rd_addr = '0;
    endtask

    task automatic rd(input int a, input logic [3:0] be, input string tag);
        rd_en = 1; rd_addr = 3'(a); rd_be = be;
        step(tag);
    endtask

    task automatic run_to(input int k, input int unsigned tgt, input string tag);
        while (mcnt[k] != tgt) begin
            inc[k] = 1'b1;
            step(tag);
        end
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) begin mcnt[k] = 0; msts[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk("R1 rst valid", {31'b0, rd_valid}, 32'd0);
        chk("R1 rst irq", {31'b0, irq}, 32'd0);
        chk("R1 rst data", rd_data, 32'd0);
        rst_n = 1;
        for (int a = 0; a < 8; a++) rd(a, 4'hF, "R1");

        // R2: mixed increment patterns, lane masking, unused addresses
        for (int i = 0; i < 23; i++) begin
            inc = 5'(1 << (i % 5)) | ((i % 3 == 0) ? 5'b10001 : 5'b0);
            if (i % 4 == 0) rd_en = 0;
            step("R2");
        end
        inc = 5'b11111; step("R2");
        for (int a = 0; a < 8; a++) rd(a, 4'hF, "R2");
        rd(2, 4'b1110, "R2");
        rd(3, 4'b0001, "R2");

        // R3 / R6: midpoint crossing of counter 0
        run_to(0, MIDV, "R3");
        rd(5, 4'hF, "R6");
        rd(5, 4'b0001, "R6");
        inc[0] = 1; step("R3");
        rd(5, 4'hF, "R3");

        // R7: upper-lane read keeps the bit, lane-0 read clears it
        rd(0, 4'b1110, "R7");
        rd(5, 4'hF, "R7");
        rd(0, 4'b0001, "R7");
        rd(5, 4'hF, "R7");

        // R4: wrap at all ones
        run_to(0, MAXV, "R4");
        rd(0, 4'b0001, "R4");
        inc[0] = 1; step("R4");
        rd(0, 4'hF, "R4");
        rd(5, 4'hF, "R4");

        // R5: saturation on counter 2
        stop = 1;
        run_to(2, MAXV, "R5");
        rd(2, 4'b0001, "R5");
        for (int i = 0; i < 3; i++) begin inc[2] = 1; step("R5"); end
        rd(2, 4'hF, "R5");
        rd(5, 4'hF, "R5");
        stop = 0;

        // R8: clearing read and top event in one cycle
        run_to(1, MAXV, "R8");
        inc[1] = 1; rd_en = 1; rd_addr = 3'd1; rd_be = 4'b0001;
        step("R8");
        rd(5, 4'hF, "R8");

        // R9: masking leaves recording intact
        mask = 5'b11111; step("R9");
        mask = 5'b00010; step("R9");
        mask = 5'b11101; step("R9");
        rd(5, 4'hF, "R9");
        for (int k = 0; k < 5; k++) rd(k, 4'b0001, "R9");
        mask = 5'b00000; step("R9");
        rd(5, 4'hF, "R9");

        // R10: bulk clear beats increment, pending bits kept
        run_to(3, MIDV, "R10");
        inc = 5'b11111; cclr = 1; step("R10");
        for (int a = 0; a < 6; a++) rd(a, 4'hF, "R10");
        inc[4] = 1; step("R10");
        rd(4, 4'hF, "R10");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule